// File: doc/BRIEF.md
# System Control Register Block with Seconds Clock

This block sits on a 32-bit register bus and gathers the housekeeping registers of a system: a power command register, an error record, a fixed version word, an I/O reset register, a bus arbitration mask and a 32-bit seconds counter. Software sets the seconds counter and can read it back. Each request gets a registered response one cycle later. The response is either an acknowledge carrying read data, or an error when the byte address is not one of the six decoded word offsets.

The seconds counter runs by itself from a prescaler that divides the input clock down to one tick per second. A write to the counter loads the new time and restarts the prescaler, so the first increment comes one full second after the load. A write of the power-off command code to the power register produces a one-cycle `pwr_off_o` pulse in the same cycle as the acknowledge for that write. Actual power sequencing is left to logic outside this block.

Top module: `sysctl_regs`

## Requirements
- R1: A request to one of the decoded offsets gets `ack_o` high and `err_o` low for exactly the one cycle after the request cycle. The decoded offsets are 0xC000 power, 0xC004 error record, 0xC008 version, 0xC00C I/O reset, 0xC010 arbitration mask and 0x9000 seconds.
- R2: A request to any other byte address, including a misaligned address near a decoded offset, gets `err_o` high and `ack_o` low in the next cycle. The read data is zero and no register changes.
- R3: The error record (0xC004) and the arbitration mask (0xC010) store all 32 written bits and return them on read.
- R4: The version (0xC008), I/O reset (0xC00C) and power (0xC000) registers always read as zero. A write to the version or I/O reset register has no visible effect.
- R5: A write of exactly 0x00000002 to 0xC000 drives `pwr_off_o` high for one cycle, the cycle in which `ack_o` answers that write. Any other value written there gives no pulse.
- R6: The seconds counter advances by one every TICK_DIV clock cycles and wraps from 0xFFFFFFFF to 0.
- R7: A write to 0x9000 loads the written value and restarts the prescaler. If the write falls in the cycle in which a tick would happen, the write wins and no increment is applied.
- R8: A read of 0x9000 returns the count held in the request cycle.
- R9: After reset, `ack_o`, `err_o` and `pwr_off_o` are low, `rdata_o` is zero, and the error record and arbitration mask read as zero.
- R10: `ack_o` and `err_o` are never high together, and neither is high unless a request was made in the cycle before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| req_i | input | 1 | Request strobe, one transfer per cycle |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | AW | Byte address within the block window |
| wdata_i | input | 32 | Write data |
| ack_o | output | 1 | Accepted response, one cycle after the request |
| err_o | output | 1 | Refused response for an address that is not decoded |
| rdata_o | output | 32 | Read data, valid with `ack_o`, zero otherwise |
| pwr_off_o | output | 1 | One-cycle power-off command pulse |

## Verification
Two things can fall in the same cycle: a software load of the seconds counter and the tick from the prescaler. The bench keeps its own model of the prescaler phase. It waits until that model is in its last count, then issues the load in exactly that cycle and reads the counter right away. The result must equal the loaded value with no increment added, and a later read must show that the prescaler restarted from the load.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;

  typedef enum logic [2:0] {
    SEL_NONE  = 3'd0,
    SEL_PWR   = 3'd1,
    SEL_ELOG  = 3'd2,
    SEL_VER   = 3'd3,
    SEL_IORST = 3'd4,
    SEL_ARB   = 3'd5,
    SEL_SECS  = 3'd6
  } reg_sel_e;

  localparam int unsigned NUM_CTRL = 5;
  localparam int unsigned DW       = 32;
  localparam logic [DW-1:0] PWR_OFF_CODE = 32'h0000_0002;

endpackage

// File: rtl/sysctl_rst_sync.sv
module sysctl_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];

endmodule

// File: rtl/sysctl_decode.sv
module sysctl_decode
  import sysctl_pkg::*;
#(
  parameter int unsigned AW = 20,
  parameter logic [AW-1:0] CTRL_BASE = 'hC000,
  parameter logic [AW-1:0] SECS_OFF  = 'h9000
) (
  input  logic [AW-1:0] addr_i,
  output reg_sel_e      sel_o
);

  localparam int unsigned NHIT = NUM_CTRL + 1;

  logic [NHIT-1:0] hit;

  for (genvar g = 0; g < NUM_CTRL; g++) begin : g_ctrl
    localparam logic [AW-1:0] OFF = CTRL_BASE + AW'(4 * g);
    assign hit[g] = (addr_i == OFF);
  end
  assign hit[NUM_CTRL] = (addr_i == SECS_OFF);

  always_comb begin
    sel_o = SEL_NONE;
    if      (hit[0]) sel_o = SEL_PWR;
    else if (hit[1]) sel_o = SEL_ELOG;
    else if (hit[2]) sel_o = SEL_VER;
    else if (hit[3]) sel_o = SEL_IORST;
    else if (hit[4]) sel_o = SEL_ARB;
    else if (hit[5]) sel_o = SEL_SECS;
  end

  // R1
  always_comb begin
    if (!$isunknown(addr_i)) begin
      onehot_hit_chk: assert ($onehot0(hit));
    end
  end

endmodule

// File: rtl/sysctl_seconds.sv
module sysctl_seconds #(
  parameter int unsigned TICK_DIV = 50_000_000,
  parameter int unsigned CW       = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [CW-1:0] load_val_i,
  output logic [CW-1:0] secs_o
);

  localparam int unsigned PW = (TICK_DIV > 2) ? $clog2(TICK_DIV) : 1;
  localparam logic [PW-1:0] PRE_LAST = PW'(TICK_DIV - 1);

  logic [PW-1:0] pre_q, pre_d;
  logic [CW-1:0] secs_q, secs_d;
  logic          tick;

  assign tick = (pre_q == PRE_LAST);

  always_comb begin
    pre_d  = pre_q + PW'(1);
    secs_d = secs_q;
    if (load_i) begin
      pre_d  = '0;
      secs_d = load_val_i;
    end else if (tick) begin
      pre_d  = '0;
      secs_d = secs_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q  <= '0;
      secs_q <= '0;
    end else begin
      pre_q  <= pre_d;
      secs_q <= secs_d;
    end
  end

  assign secs_o = secs_q;

  // R7
  load_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (secs_o == $past(load_val_i)));

  // R6
  hold_between_ticks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && !tick) |=> $stable(secs_o));

  // R6
  pre_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pre_q <= PRE_LAST);

endmodule

// File: rtl/sysctl_pwr_cmd.sv
module sysctl_pwr_cmd
  import sysctl_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_stb_i,
  input  logic [DW-1:0] wdata_i,
  output logic          pulse_o
);

  logic pulse_q, pulse_d;

  always_comb pulse_d = wr_stb_i && (wdata_i == PWR_OFF_CODE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pulse_q <= 1'b0;
    else        pulse_q <= pulse_d;
  end

  assign pulse_o = pulse_q;

endmodule

// File: rtl/sysctl_regs.sv
module sysctl_regs
  import sysctl_pkg::*;
#(
  parameter int unsigned AW        = 20,
  parameter int unsigned TICK_DIV  = 50_000_000,
  parameter logic [AW-1:0] CTRL_BASE = 'hC000,
  parameter logic [AW-1:0] SECS_OFF  = 'h9000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [31:0]   wdata_i,
  output logic          ack_o,
  output logic          err_o,
  output logic [31:0]   rdata_o,
  output logic          pwr_off_o
);

  logic     rst_n_s;
  reg_sel_e sel;
  logic     accept, refuse, wr_acc, rd_acc;
  logic [DW-1:0] secs;
  logic [DW-1:0] elog_q, arb_q;
  logic          elog_en, arb_en;
  logic          ack_q, err_q;
  logic [DW-1:0] rdata_q, rdata_d;

  sysctl_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_s));

  sysctl_decode #(.AW(AW), .CTRL_BASE(CTRL_BASE), .SECS_OFF(SECS_OFF)) u_dec (
    .addr_i(addr_i), .sel_o(sel));

  assign accept = req_i && (sel != SEL_NONE);
  assign refuse = req_i && (sel == SEL_NONE);
  assign wr_acc = accept && we_i;
  assign rd_acc = accept && !we_i;

  sysctl_seconds #(.TICK_DIV(TICK_DIV), .CW(DW)) u_secs (
    .clk(clk), .rst_n(rst_n_s),
    .load_i(wr_acc && (sel == SEL_SECS)), .load_val_i(wdata_i),
    .secs_o(secs));

  sysctl_pwr_cmd u_pwr (
    .clk(clk), .rst_n(rst_n_s),
    .wr_stb_i(wr_acc && (sel == SEL_PWR)), .wdata_i(wdata_i),
    .pulse_o(pwr_off_o));

  assign elog_en = wr_acc && (sel == SEL_ELOG);
  assign arb_en  = wr_acc && (sel == SEL_ARB);

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s)     elog_q <= '0;
    else if (elog_en) elog_q <= wdata_i;
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s)    arb_q <= '0;
    else if (arb_en) arb_q <= wdata_i;
  end

  always_comb begin
    rdata_d = '0;
    if (rd_acc) begin
      unique case (sel)
        SEL_ELOG: rdata_d = elog_q;
        SEL_ARB:  rdata_d = arb_q;
        SEL_SECS: rdata_d = secs;
        default:  rdata_d = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      ack_q   <= 1'b0;
      err_q   <= 1'b0;
      rdata_q <= '0;
    end else begin
      ack_q   <= accept;
      err_q   <= refuse;
      rdata_q <= rdata_d;
    end
  end

  assign ack_o   = ack_q;
  assign err_o   = err_q;
  assign rdata_o = rdata_q;

  // R10
  ack_err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    !(ack_o && err_o));

  // R10
  resp_after_req_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (ack_o || err_o) |-> $past(req_i));

  // R2
  err_zero_data_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    err_o |-> (rdata_o == '0));

  // R5
  pwr_with_ack_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    pwr_off_o |-> ack_o);

  // R5
  pwr_single_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    pwr_off_o |=> !pwr_off_o);

endmodule

// File: tb/sysctl_regs_test.sv
module sysctl_regs_test;

  localparam int unsigned AW  = 20;
  localparam int unsigned DIV = 8;
  localparam logic [AW-1:0] A_PWR  = 20'hC000;
  localparam logic [AW-1:0] A_ELOG = 20'hC004;
  localparam logic [AW-1:0] A_VER  = 20'hC008;
  localparam logic [AW-1:0] A_IORS = 20'hC00C;
  localparam logic [AW-1:0] A_ARB  = 20'hC010;
  localparam logic [AW-1:0] A_SECS = 20'h9000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req = 1'b0, we = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [31:0] wdata = '0;
  logic ack, err, pwr_off;
  logic [31:0] rdata;

  int n_chk = 0, n_fail = 0;
  int cyc = 0;
  bit done = 0;

  // bench model state
  int unsigned m_pre = 0;
  logic [31:0] m_secs = '0;
  logic [31:0] m_elog = '0, m_arb = '0;
  bit secs_known = 0;

  always #10 clk = ~clk;

  sysctl_regs #(.AW(AW), .TICK_DIV(DIV)) uut (
    .clk(clk), .rst_n(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .ack_o(ack), .err_o(err), .rdata_o(rdata),
    .pwr_off_o(pwr_off));

  // seconds model: loads win, otherwise a tick every DIV cycles
  always @(posedge clk) begin
    if (req && we && addr == A_SECS) begin
      m_pre  <= 0;
      m_secs <= wdata;
    end else if (m_pre == DIV - 1) begin
      m_pre  <= 0;
      m_secs <= m_secs + 32'd1;
    end else begin
      m_pre <= m_pre + 1;
    end
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000 && !done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: run hung, actual cycles=%0d expected<150000", cyc);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  function automatic bit listed(input logic [AW-1:0] a);
    return a == A_PWR || a == A_ELOG || a == A_VER || a == A_IORS ||
           a == A_ARB || a == A_SECS;
  endfunction

  function automatic logic [31:0] model_read(input logic [AW-1:0] a);
    if (a == A_ELOG) return m_elog;
    if (a == A_ARB)  return m_arb;
    if (a == A_SECS) return m_secs;
    return 32'd0;
  endfunction

  task automatic xact(input logic w, input logic [AW-1:0] a, input logic [31:0] d);
    bit ok_addr, exp_pwr, chk_data;
    logic [31:0] exp_rd;
    @(negedge clk);
    // previous pulse, if any, must be gone (R5 single cycle)
    chk(pwr_off == 1'b0, "R5 pulse width", {31'd0, pwr_off}, 32'd0);
    ok_addr  = listed(a);
    exp_pwr  = w && a == A_PWR && d == 32'h2;
    exp_rd   = (!w && ok_addr) ? model_read(a) : 32'd0;
    chk_data = !( !w && a == A_SECS && !secs_known);
    req = 1'b1; we = w; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
    chk(ack == ok_addr && err == !ok_addr, ok_addr ? "R1/R10 ack" : "R2/R10 err",
        {30'd0, ack, err}, {30'd0, ok_addr, !ok_addr});
    if (chk_data)
      chk(rdata == exp_rd, (a == A_SECS) ? "R8 secs read" : "R3/R4 read data", rdata, exp_rd);
    chk(pwr_off == exp_pwr, "R5 power pulse", {31'd0, pwr_off}, {31'd0, exp_pwr});
    if (w && a == A_ELOG) m_elog = d;
    if (w && a == A_ARB)  m_arb  = d;
    if (w && a == A_SECS) secs_known = 1;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'd2718));
    idle(4);
    rst_n = 1'b1;
    idle(4);
    // R9 reset state
    chk(ack == 0 && err == 0 && pwr_off == 0, "R9 reset outputs",
        {29'd0, ack, err, pwr_off}, 32'd0);
    chk(rdata == 0, "R9 reset rdata", rdata, 32'd0);
    xact(0, A_ELOG, 0);
    xact(0, A_ARB, 0);
    // R3 storage
    xact(1, A_ELOG, 32'hDEAD_BEEF);
    xact(1, A_ARB, 32'hA5A5_0F0F);
    xact(0, A_ELOG, 0);
    xact(0, A_ARB, 0);
    // R4 read-as-zero and ignored writes
    xact(1, A_VER, 32'hFFFF_FFFF);
    xact(0, A_VER, 0);
    xact(1, A_IORS, 32'hFFFF_FFFF);
    xact(0, A_IORS, 0);
    xact(0, A_PWR, 0);
    xact(0, A_ELOG, 0);
    // R5 command code only
    xact(1, A_PWR, 32'h3);
    xact(1, A_PWR, 32'h1_0002);
    xact(1, A_PWR, 32'h2);
    xact(0, A_PWR, 0);
    // R2 refused addresses leave state alone
    xact(1, 20'hC014, 32'h1111_1111);
    xact(1, 20'hC006, 32'h2222_2222);
    xact(0, 20'h00000, 0);
    xact(0, 20'h9004, 0);
    xact(0, A_ELOG, 0);
    // R7 load then immediate read
    xact(1, A_SECS, 32'h1234_5678);
    xact(0, A_SECS, 0);
    chk(rdata == 32'h1234_5678 || rdata == 32'h1234_5679, "R7 loaded value", rdata, 32'h1234_5678);
    // R6 advance over several ticks
    idle(3 * DIV + 2);
    xact(0, A_SECS, 0);
    // R6 wrap
    xact(1, A_SECS, 32'hFFFF_FFFF);
    idle(DIV);
    xact(0, A_SECS, 0);
    chk(rdata == 32'd0, "R6 wrap to zero", rdata, 32'd0);
    // R7 load colliding with a tick: wait for last prescaler phase
    while (m_pre != DIV - 2) @(negedge clk);
    // xact drives on the next negedge, where the model sits at DIV-1
    xact(1, A_SECS, 32'h0000_0100);
    xact(0, A_SECS, 0);
    chk(rdata == 32'h0000_0100, "R7 load wins over tick", rdata, 32'h0000_0100);
    idle(DIV);
    xact(0, A_SECS, 0);
    // random mix
    for (int k = 0; k < 400; k++) begin
      logic [AW-1:0] a;
      logic [31:0] d;
      logic w;
      int unsigned pick;
      pick = $urandom_range(0, 7);
      case (pick)
        0: a = A_PWR;
        1: a = A_ELOG;
        2: a = A_VER;
        3: a = A_IORS;
        4: a = A_ARB;
        5: a = A_SECS;
        6: a = AW'($urandom);
        default: a = 20'hC000 + AW'($urandom_range(0, 19));
      endcase
      w = 1'($urandom);
      d = ($urandom_range(0, 1) == 1 && a == A_PWR) ? 32'h2 : $urandom;
      xact(w, a, d);
      idle($urandom_range(0, 3));
    end
    idle(2);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule